// File: doc/BRIEF.md
# Shared Memory Host Arbiter

This block decides who may use one buffer memory that is shared between an on-chip bus master (for example the DMA side of a network controller) and an external host. The host asks for the memory with an asynchronous request line. It asks for a register (slave) access with a chip-select line, and each register transfer is framed by an address strobe. The block answers with a single acknowledge output. It also tells the on-chip master to stay off the bus through a hold-off output.

All three host inputs are captured on the falling bus-clock edge and then pass through two rising-edge flip-flops before the controller acts on them. If the on-chip master is busy, the controller waits for its transfer to drain before it grants the host. The drain time is a fixed base plus the wait-state count the master reports. A memory grant lasts until the host drops its request. A register grant makes the acknowledge follow the address strobe, so it pulses once for every register access. There is no data path, so every pin is a plain control or status line, with no valid/ready handshake and no back-pressure.

Top module: `smh_arbiter`

## Requirements
- R1: While reset is active, and directly after it, host_ack, mst_holdoff, slave_cycle and proto_err are all 0.
- R2: host_ack changes only on falling clock edges. host_req, host_sel and host_strobe each take effect only after capture on a falling edge followed by two rising-edge stages.
- R3: With mst_busy low, host_ack rises on the third falling edge after the falling edge that first samples host_req high.
- R4: With mst_busy high when the synchronized request is seen, host_ack rises on falling edge 7 + mst_wait after the sampling edge (drain base 4), provided that the master has stopped being busy by then.
- R5: If the drain count has run out but mst_busy is still high, the grant waits for a mst_done pulse. host_ack then rises on the second falling edge after the bench raises mst_done just past a rising edge.
- R6: A memory grant holds host_ack at 1 for as long as host_req stays high. host_strobe activity has no effect on host_ack during a memory grant.
- R7: After host_req drops, host_ack falls on the third falling edge after the edge that samples it low.
- R8: With host_sel held and the register grant in place, slave_cycle is 1 and host_ack follows the strobe two falling edges after the strobe is sampled. The strobe is active when low if strobe_mode = 0, and active when high if strobe_mode = 1.
- R9: If host_req and host_sel are both active in the same synchronized cycle, proto_err is 1 and host_ack stays 0.
- R10: mst_holdoff is 1 while a synchronized host request is pending, draining or granted, and it returns to 0 once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Asynchronous host memory request, active high |
| host_sel | input | 1 | Asynchronous host register chip select, active high |
| host_strobe | input | 1 | Address strobe framing each register access |
| strobe_mode | input | 1 | 0: strobe active low, 1: strobe active high |
| mst_busy | input | 1 | On-chip master is in a transfer |
| mst_done | input | 1 | One-cycle pulse at the end of a master transfer |
| mst_wait | input | WAIT_W | Wait states in the master's current transfer |
| host_ack | output | 1 | Grant to the host, changes on falling edges |
| mst_holdoff | output | 1 | Tells the on-chip master not to start a transfer |
| slave_cycle | output | 1 | Register (slave) grant is active |
| proto_err | output | 1 | Request and chip select were seen together |

## Verification
The memory grant is exercised from an idle master, from a busy master with wait counts 0 and 3, and from a master that is still busy after the drain count runs out. Together these separate the plain synchronizer latency, the wait-state extension and the extra wait for the done pulse. Register accesses are repeated under both strobe polarities. This shows that the acknowledge follows the strobe and that its sense inverts with the mode. A strobe wiggle during a memory grant, and a collision of request and chip select, check that the grant ignores the strobe and that a collision produces neither grant.

// File: rtl/smh_pkg.sv
package smh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_MEM   = 2'd2,
    ST_SLV   = 2'd3
  } arb_state_e;
endpackage

// File: rtl/smh_sync.sv
module smh_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  // Capture on the falling edge, then STAGES rising-edge flops.
  logic [W-1:0] cap_n;
  logic [W-1:0] pipe [STAGES];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cap_n <= '0;
    else        cap_n <= d_async;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= cap_n;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign d_sync = pipe[STAGES-1];

  // R2: a synchronized rise must have been captured on a falling edge first
  a_r2_sync_from_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_sync[0]) |-> $past(pipe[0][0]));
endmodule

// File: rtl/smh_ctrl.sv
module smh_ctrl
  import smh_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int DRAIN_BASE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              sel_s,
  input  logic              mst_busy,
  input  logic              mst_done,
  input  logic [WAIT_W-1:0] mst_wait,
  output arb_state_e        st,
  output logic              proto_err
);
  localparam int CNT_W = $clog2(DRAIN_BASE + (1 << WAIT_W) + 1);

  arb_state_e       st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             to_reg, to_reg_n;
  logic             both;
  logic             want;

  assign both = req_s && sel_s;
  assign want = to_reg ? sel_s : req_s;

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    to_reg_n = to_reg;
    unique case (st)
      ST_IDLE: begin
        if (!both && (req_s || sel_s)) begin
          to_reg_n = sel_s;
          if (mst_busy) begin
            st_n  = ST_DRAIN;
            cnt_n = CNT_W'(DRAIN_BASE) + CNT_W'(mst_wait);
          end else begin
            st_n = sel_s ? ST_SLV : ST_MEM;
          end
        end
      end
      ST_DRAIN: begin
        if (both || !want) begin
          st_n = ST_IDLE;
        end else if (cnt == CNT_W'(1)) begin
          if (!mst_busy || mst_done) st_n = to_reg ? ST_SLV : ST_MEM;
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      ST_MEM: if (!req_s || both) st_n = ST_IDLE;
      ST_SLV: if (!sel_s || both) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      to_reg    <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      to_reg    <= to_reg_n;
      proto_err <= both;
    end
  end

  // R4: the drain counter never sits at zero while draining
  a_r4_drain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN) |-> (cnt != '0));
  // R6: a memory grant persists while the request stays alone
  a_r6_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MEM && req_s && !sel_s) |=> (st == ST_MEM));
  // R9: a collision leaves the controller idle
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (st == ST_IDLE));
endmodule

// File: rtl/smh_ack.sv
module smh_ack
  import smh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  arb_state_e st,
  input  logic       strobe_s,
  input  logic       strobe_mode,
  output logic       host_ack
);
  logic strobe_on;
  logic ack_d;

  assign strobe_on = strobe_mode ? strobe_s : !strobe_s;
  assign ack_d     = (st == ST_MEM) || ((st == ST_SLV) && strobe_on);

  // Acknowledge launches on the falling edge of the granting state.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) host_ack <= 1'b0;
    else        host_ack <= ack_d;
  end

  // R3: two idle cycles in a row leave no acknowledge behind
  a_r3_idle_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE) |-> !host_ack);
endmodule

// File: rtl/smh_arbiter.sv
module smh_arbiter
  import smh_pkg::*;
#(
  parameter int WAIT_W      = 4,
  parameter int DRAIN_BASE  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_sel,
  input  logic              host_strobe,
  input  logic              strobe_mode,
  input  logic              mst_busy,
  input  logic              mst_done,
  input  logic [WAIT_W-1:0] mst_wait,
  output logic              host_ack,
  output logic              mst_holdoff,
  output logic              slave_cycle,
  output logic              proto_err
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw_in, syn;
  arb_state_e      st;

  assign raw_in = {host_strobe, host_sel, host_req};

  smh_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .d_sync  (syn)
  );

  smh_ctrl #(.WAIT_W(WAIT_W), .DRAIN_BASE(DRAIN_BASE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (syn[0]),
    .sel_s     (syn[1]),
    .mst_busy  (mst_busy),
    .mst_done  (mst_done),
    .mst_wait  (mst_wait),
    .st        (st),
    .proto_err (proto_err)
  );

  smh_ack u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st),
    .strobe_s    (syn[2]),
    .strobe_mode (strobe_mode),
    .host_ack    (host_ack)
  );

  assign mst_holdoff = (st != ST_IDLE) || syn[0] || syn[1];
  assign slave_cycle = (st == ST_SLV);

  // R10: the host never holds acknowledge while the master is free to run
  a_r10_ack_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> mst_holdoff);
  // R9: a flagged collision never coexists with a grant
  a_r9_err_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !host_ack);
endmodule

// File: tb/smh_arbiter_bench.sv
`timescale 1ns/1ps
module smh_arbiter_bench;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic host_req, host_sel, host_strobe, strobe_mode;
  logic mst_busy, mst_done;
  logic [WAIT_W-1:0] mst_wait;
  logic host_ack, mst_holdoff, slave_cycle, proto_err;

  always #10 clk = ~clk;

  smh_arbiter #(.WAIT_W(WAIT_W)) u_smh_arbiter (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_sel(host_sel),
    .host_strobe(host_strobe), .strobe_mode(strobe_mode),
    .mst_busy(mst_busy), .mst_done(mst_done), .mst_wait(mst_wait),
    .host_ack(host_ack), .mst_holdoff(mst_holdoff),
    .slave_cycle(slave_cycle), .proto_err(proto_err)
  );

  typedef struct {
    int    edge_n;
    bit    val;
    string tag;
  } exp_t;
  exp_t q[$];

  int total = 0;
  int bad = 0;
  int ncnt = 0;
  int midcycle_bad = 0;
  logic prev_ack = 1'b0;
  bit done_run = 0;

  always @(negedge clk) ncnt++;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int e, bit v, string tag);
    exp_t x;
    x.edge_n = e; x.val = v; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Monitor: pops the scoreboard whenever host_ack changes
  initial begin
    forever begin
      @(negedge clk); #5;
      if (host_ack !== prev_ack) begin
        if (q.size() == 0) begin
          chk(0, "R6 unexpected ack change", int'(host_ack), int'(prev_ack));
        end else begin
          exp_t x;
          x = q.pop_front();
          chk(x.edge_n == ncnt, {x.tag, " edge"}, ncnt, x.edge_n);
          chk(x.val == host_ack, {x.tag, " value"}, int'(host_ack), int'(x.val));
        end
        prev_ack = host_ack;
      end
    end
  end

  // R2: acknowledge must not move between a falling edge and the next rising one
  initial begin
    forever begin
      @(posedge clk); #5;
      if (rst_n && host_ack !== prev_ack) midcycle_bad++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_req = 0; host_sel = 0; host_strobe = 1; strobe_mode = 0;
    mst_busy = 0; mst_done = 0; mst_wait = '0;
    ticks(3);
    chk(host_ack == 0 && mst_holdoff == 0, "R1 in reset", int'(host_ack), 0);
    rst_n = 1'b1;
    ticks(4);
    chk({host_ack, mst_holdoff, slave_cycle, proto_err} == 4'b0, "R1 after reset",
        int'({host_ack, mst_holdoff, slave_cycle, proto_err}), 0);

    // R3 idle grant, R6 strobe ignored, R7 release, R10 holdoff
    tick(); host_req = 1; push(ncnt + 4, 1, "R3 idle grant");
    ticks(6);
    chk(mst_holdoff == 1, "R10 holdoff in grant", int'(mst_holdoff), 1);
    host_strobe = 0; ticks(4); host_strobe = 1; ticks(4);
    chk(host_ack == 1, "R6 strobe ignored", int'(host_ack), 1);
    host_req = 0; push(ncnt + 4, 0, "R7 release");
    ticks(6);
    chk(mst_holdoff == 0, "R10 holdoff idle", int'(mst_holdoff), 0);

    // R4 busy master with two wait counts
    for (int w = 0; w <= 3; w += 3) begin
      mst_busy = 1; mst_wait = WAIT_W'(w);
      tick(); host_req = 1; push(ncnt + 8 + w, 1, "R4 busy grant");
      ticks(5); mst_busy = 0;
      ticks(10 + w);
      host_req = 0; push(ncnt + 4, 0, "R7 release");
      ticks(6);
    end

    // R5 master still busy after drain, done pulse releases it
    mst_busy = 1; mst_wait = '0;
    tick(); host_req = 1;
    ticks(15);
    chk(host_ack == 0, "R5 waits for done", int'(host_ack), 0);
    chk(mst_holdoff == 1, "R10 holdoff while draining", int'(mst_holdoff), 1);
    mst_done = 1; push(ncnt + 2, 1, "R5 grant after done");
    tick(); mst_done = 0; mst_busy = 0;
    ticks(5);
    host_req = 0; push(ncnt + 4, 0, "R7 release");
    ticks(6);

    // R8 register access, strobe active low
    host_sel = 1; ticks(8);
    chk(slave_cycle == 1, "R8 slave cycle", int'(slave_cycle), 1);
    chk(host_ack == 0, "R8 no ack without strobe", int'(host_ack), 0);
    for (int k = 0; k < 2; k++) begin
      host_strobe = 0; push(ncnt + 3, 1, "R8 strobe low mode0");
      ticks(5);
      host_strobe = 1; push(ncnt + 3, 0, "R8 strobe idle mode0");
      ticks(5);
    end
    host_sel = 0; ticks(6);
    chk(slave_cycle == 0, "R8 slave cycle ends", int'(slave_cycle), 0);

    // R8 register access, strobe active high
    strobe_mode = 1; host_strobe = 0; ticks(4);
    host_sel = 1; ticks(8);
    host_strobe = 1; push(ncnt + 3, 1, "R8 strobe high mode1");
    ticks(5);
    host_strobe = 0; push(ncnt + 3, 0, "R8 strobe idle mode1");
    ticks(5);
    host_sel = 0; ticks(6);

    // R9 collision
    strobe_mode = 0; host_strobe = 1; ticks(4);
    host_req = 1; host_sel = 1;
    ticks(6);
    chk(proto_err == 1, "R9 collision flagged", int'(proto_err), 1);
    chk(host_ack == 0, "R9 no grant", int'(host_ack), 0);
    host_req = 0; host_sel = 0;
    ticks(6);
    chk(proto_err == 0, "R9 flag clears", int'(proto_err), 0);

    chk(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    chk(midcycle_bad == 0, "R2 ack only on falling edges", midcycle_bad, 0);
    done_run = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule